// File: doc/BRIEF.md
# Debug Halt Entry Sequencer

This block takes a small CPU core out of normal execution and parks it in a halted debug state. Two sources can start the move. One is a debug request from the host over the test access port. The other is a hit reported by the breakpoint comparators. Both sources lead to the same behaviour.

Once a start is accepted, the block steps through a fixed, one-cycle-per-step sequence. First it stops instruction fetch. Next it saves the interrupted program counter on the stack. It then forces the instruction pointer to a fixed ROM service address and drops the global interrupt enable. Finally it holds the core halted. For the whole of debug, the clock enables of the general timers and of the watchdog are forced low, so hardware timing does not drift relative to the user program.

A return strobe from the debug command engine ends debug mode. On return the block pops the stack and restores the instruction pointer. It then releases the halt and the timer clocks. The interrupt enable is deliberately left for software to set again.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: When idle, a high `host_dbg_req` or `bkpt_hit` at a clock edge starts entry, and `fetch_block` is high in the cycle after that edge. Both triggers high in the same cycle start exactly one sequence, with a single stack push.
- R2: Entry steps are one cycle each, counted from the accepting edge. Step 1 has only `fetch_block` high. Step 2 adds `stk_push`. Step 3 adds `ip_load`. Step 4 is the interrupt-enable step. From step 5 on, `cpu_halt` is high. `fetch_block` stays high from step 1 until the block is idle again.
- R3: During step 3, `ip_load_val` equals the fixed vector 0x8010, whatever the interrupt vector would be. During step 2, `stk_push_addr` equals the `cur_pc` value present in the accepting cycle, even if `cur_pc` changes afterwards.
- R4: `ige_clr` is high during step 4 only when `ige_in` is high. It is never high in any other cycle.
- R5: While not idle, further host requests or breakpoint hits have no effect: no second push, and the step timing and halt are unchanged.
- R6: From step 1 until the block is idle again, every bit of `tmr_clk_en` and `wdt_clk_en` is 0. When idle, they equal `tmr_run` and `wdt_run`.
- R7: `cpu_halt` and `entry_done` are high from step 5 and stay high until a return is taken.
- R8: `ret_req` high while halted causes, in the next cycle, one cycle with `stk_pop` and `ip_restore` high and `cpu_halt` and `ige_clr` low. After that cycle the block is idle, with fetch released and timers running.
- R9: `ret_req` high while not halted (idle or entry steps 1 to 4) has no effect.
- R10: After reset every strobe is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_dbg_req | input | 1 | Debug request from the host port |
| bkpt_hit | input | 1 | Breakpoint comparator match |
| ret_req | input | 1 | Return-to-run strobe from the command engine |
| ige_in | input | 1 | Current global interrupt enable |
| cur_pc | input | ADDR_W | Address of the next instruction (return address) |
| tmr_run | input | N_TMR | Run enables of the general timers |
| wdt_run | input | 1 | Run enable of the watchdog |
| fetch_block | output | 1 | Stop program fetch |
| stk_push | output | 1 | Push strobe to the stack |
| stk_push_addr | output | ADDR_W | Return address to push |
| ip_load | output | 1 | Instruction pointer load strobe |
| ip_load_val | output | ADDR_W | Value to load into the instruction pointer |
| ige_clr | output | 1 | Clear strobe for the global interrupt enable |
| cpu_halt | output | 1 | Halt the core |
| entry_done | output | 1 | Entry sequence has completed |
| stk_pop | output | 1 | Pop strobe to the stack on return |
| ip_restore | output | 1 | Restore the instruction pointer from the popped value |
| tmr_clk_en | output | N_TMR | Gated timer clock enables |
| wdt_clk_en | output | 1 | Gated watchdog clock enable |

## Verification
The entry and return path is swept over every trigger combination (host only, breakpoint only, both together) and both interrupt-enable levels. It is also run with a return address that changes after acceptance. The simultaneous case separates a single merged start from a doubled sequence. The two enable levels separate a conditional clear from an unconditional one. The changing `cur_pc` shows that the address is captured at acceptance. Each combination is repeated with triggers held high through the whole of debug and with early return strobes during entry, which separates ignored inputs from ones that leak into the sequence.

// File: rtl/dbg_entry_pkg.sv
// Shared types for the debug entry controller.
// Assumes: state encoding is internal and never leaves the block.
package dbg_entry_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_BLOCK = 3'd1,
        ST_PUSH  = 3'd2,
        ST_VECT  = 3'd3,
        ST_IGE   = 3'd4,
        ST_HALT  = 3'd5,
        ST_RET   = 3'd6
    } dbg_st_e;

endpackage

// File: rtl/dbg_trig_merge.sv
// Merges the host debug request and the breakpoint hit into one start pulse.
// Assumes: both inputs are synchronous to clk; `accepting` is high only when
// the sequencer is idle, so triggers seen at any other time are dropped.
module dbg_trig_merge (
    input  logic host_req,
    input  logic bkpt_hit,
    input  logic accepting,
    output logic start
);

    // Either source, or both at once, produces a single start request.
    always_comb begin
        start = accepting & (host_req | bkpt_hit);
    end

endmodule

// File: rtl/dbg_entry_seq.sv
// One-cycle-per-step sequencer for debug entry and return.
// Assumes: `start` is only raised while `idle` is high; `ret_req` is only
// honoured in the halt state. The return address is captured at acceptance.
module dbg_entry_seq
    import dbg_entry_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] VECTOR = 16'h8010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ret_req,
    input  logic              ige_in,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic              idle,
    output logic              fetch_block,
    output logic              stk_push,
    output logic [ADDR_W-1:0] stk_push_addr,
    output logic              ip_load,
    output logic [ADDR_W-1:0] ip_load_val,
    output logic              ige_clr,
    output logic              cpu_halt,
    output logic              entry_done,
    output logic              stk_pop,
    output logic              ip_restore
);

    dbg_st_e           state_q;
    dbg_st_e           state_d;
    logic [ADDR_W-1:0] ret_addr_q;

    // Next-state selection: the fixed entry order, then halt until return.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (start) state_d = ST_BLOCK;
            ST_BLOCK: state_d = ST_PUSH;
            ST_PUSH:  state_d = ST_VECT;
            ST_VECT:  state_d = ST_IGE;
            ST_IGE:   state_d = ST_HALT;
            ST_HALT:  if (ret_req) state_d = ST_RET;
            ST_RET:   state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Return address capture in the accepting cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ret_addr_q <= '0;
        else if (state_q == ST_RUN && start) ret_addr_q <= cur_pc;
    end

    // Strobe decode per state.
    always_comb begin
        idle          = (state_q == ST_RUN);
        fetch_block   = (state_q != ST_RUN);
        stk_push      = (state_q == ST_PUSH);
        stk_push_addr = ret_addr_q;
        ip_load       = (state_q == ST_VECT);
        ip_load_val   = VECTOR;
        ige_clr       = (state_q == ST_IGE) & ige_in;
        cpu_halt      = (state_q == ST_HALT);
        entry_done    = (state_q == ST_HALT);
        stk_pop       = (state_q == ST_RET);
        ip_restore    = (state_q == ST_RET);
    end

    AST_PUSH_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> ip_load);                                          // R2
    AST_LOAD_THEN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |-> ##2 cpu_halt);                                      // R2
    AST_IGE_CLR_IN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ige_clr |-> (fetch_block && !cpu_halt && !stk_pop));            // R4
    AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> !stk_push);                                        // R5
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !ret_req) |=> cpu_halt);                           // R7
    AST_POP_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        stk_pop |-> ($past(cpu_halt) && !cpu_halt && !ige_clr));        // R8
    AST_RET_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && ret_req && !start) |=> idle);                          // R9

endmodule

// File: rtl/dbg_clk_freeze.sv
// Gates the run enables of the timers and the watchdog while in debug.
// Assumes: downstream timers use the enables as clock enables, not as clocks.
module dbg_clk_freeze #(
    parameter int N_TMR = 4
) (
    input  logic             freeze,
    input  logic [N_TMR-1:0] tmr_run,
    input  logic             wdt_run,
    output logic [N_TMR-1:0] tmr_en,
    output logic             wdt_en
);

    // One gate per timer.
    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr_gate
        always_comb begin
            tmr_en[g] = tmr_run[g] & ~freeze;
        end
    end

    // Watchdog gate, frozen alike.
    always_comb begin
        wdt_en = wdt_run & ~freeze;
    end

endmodule

// File: rtl/dbg_entry_ctrl.sv
// Top of the debug entry controller: trigger merge, entry sequencer and
// timer freeze. Assumes synchronous inputs and a synchronous active-low reset.
module dbg_entry_ctrl #(
    parameter int                ADDR_W     = 16,
    parameter int                N_TMR      = 4,
    parameter logic [ADDR_W-1:0] DBG_VECTOR = 16'h8010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_dbg_req,
    input  logic              bkpt_hit,
    input  logic              ret_req,
    input  logic              ige_in,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [N_TMR-1:0]  tmr_run,
    input  logic              wdt_run,
    output logic              fetch_block,
    output logic              stk_push,
    output logic [ADDR_W-1:0] stk_push_addr,
    output logic              ip_load,
    output logic [ADDR_W-1:0] ip_load_val,
    output logic              ige_clr,
    output logic              cpu_halt,
    output logic              entry_done,
    output logic              stk_pop,
    output logic              ip_restore,
    output logic [N_TMR-1:0]  tmr_clk_en,
    output logic              wdt_clk_en
);

    localparam logic [N_TMR-1:0] TMR_OFF = '0;

    logic seq_idle;
    logic seq_start;

    dbg_trig_merge u_merge (
        .host_req  (host_dbg_req),
        .bkpt_hit  (bkpt_hit),
        .accepting (seq_idle),
        .start     (seq_start)
    );

    dbg_entry_seq #(
        .ADDR_W (ADDR_W),
        .VECTOR (DBG_VECTOR)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (seq_start),
        .ret_req       (ret_req),
        .ige_in        (ige_in),
        .cur_pc        (cur_pc),
        .idle          (seq_idle),
        .fetch_block   (fetch_block),
        .stk_push      (stk_push),
        .stk_push_addr (stk_push_addr),
        .ip_load       (ip_load),
        .ip_load_val   (ip_load_val),
        .ige_clr       (ige_clr),
        .cpu_halt      (cpu_halt),
        .entry_done    (entry_done),
        .stk_pop       (stk_pop),
        .ip_restore    (ip_restore)
    );

    dbg_clk_freeze #(
        .N_TMR (N_TMR)
    ) u_freeze (
        .freeze  (~seq_idle),
        .tmr_run (tmr_run),
        .wdt_run (wdt_run),
        .tmr_en  (tmr_clk_en),
        .wdt_en  (wdt_clk_en)
    );

    AST_TIMERS_FROZEN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> (tmr_clk_en == TMR_OFF && !wdt_clk_en));           // R6
    AST_TIMERS_FROZEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_block |-> (tmr_clk_en == TMR_OFF && !wdt_clk_en));        // R6
    AST_ENTRY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_block && (host_dbg_req || bkpt_hit)) |=> fetch_block);  // R1
    AST_LOAD_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |-> (ip_load_val == DBG_VECTOR && fetch_block));        // R3

endmodule

// File: tb/sim_dbg_entry_ctrl.sv
module sim_dbg_entry_ctrl;

    localparam int ADDR_W = 16;
    localparam int N_TMR  = 4;
    localparam logic [ADDR_W-1:0] VEC = 16'h8010;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_dbg_req = 1'b0;
    logic              bkpt_hit = 1'b0;
    logic              ret_req = 1'b0;
    logic              ige_in = 1'b0;
    logic [ADDR_W-1:0] cur_pc = '0;
    logic [N_TMR-1:0]  tmr_run = 4'b1011;
    logic              wdt_run = 1'b1;
    logic              fetch_block, stk_push, ip_load, ige_clr, cpu_halt;
    logic              entry_done, stk_pop, ip_restore, wdt_clk_en;
    logic [ADDR_W-1:0] stk_push_addr, ip_load_val;
    logic [N_TMR-1:0]  tmr_clk_en;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    dbg_entry_ctrl #(.ADDR_W(ADDR_W), .N_TMR(N_TMR), .DBG_VECTOR(VEC)) u0 (
        .clk(clk), .rst_n(rst_n), .host_dbg_req(host_dbg_req),
        .bkpt_hit(bkpt_hit), .ret_req(ret_req), .ige_in(ige_in),
        .cur_pc(cur_pc), .tmr_run(tmr_run), .wdt_run(wdt_run),
        .fetch_block(fetch_block), .stk_push(stk_push),
        .stk_push_addr(stk_push_addr), .ip_load(ip_load),
        .ip_load_val(ip_load_val), .ige_clr(ige_clr), .cpu_halt(cpu_halt),
        .entry_done(entry_done), .stk_pop(stk_pop), .ip_restore(ip_restore),
        .tmr_clk_en(tmr_clk_en), .wdt_clk_en(wdt_clk_en)
    );

    // Compare the strobe vector for a step; step 0 idle, 1..5 entry, 6 return.
    task automatic check_step(input int s, input logic ige, input string req);
        logic [13:0] act, exp;
        logic frz;
        frz = (s != 0);
        act = {fetch_block, stk_push, ip_load, ige_clr, cpu_halt, entry_done,
               stk_pop, ip_restore, tmr_clk_en, wdt_clk_en};
        exp = {(s >= 1), (s == 2), (s == 3), (s == 4) & ige, (s == 5), (s == 5),
               (s == 6), (s == 6), frz ? 4'b0000 : tmr_run, frz ? 1'b0 : wdt_run};
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s step %0d: actual %b expected %b", req, s, act, exp);
        end
    endtask

    task automatic check_val(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] e,
                             input string req);
        n_checks++;
        if (a !== e) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, a, e);
        end
    endtask

    // One full entry/return cycle; trig bit0 host, bit1 breakpoint.
    // mode 0 plain, 1 triggers held through debug (R5), 2 early returns (R9).
    task automatic run_case(input int trig, input logic ige, input int mode,
                            input logic [ADDR_W-1:0] pc);
        @(negedge clk);
        ige_in = ige;
        cur_pc = pc;
        host_dbg_req = trig[0];
        bkpt_hit = trig[1];
        for (int s = 1; s <= 5; s++) begin
            @(negedge clk);
            check_step(s, ige, (s == 1) ? "R1" : (s == 4) ? "R4" :
                       (mode == 1) ? "R5" : (mode == 2) ? "R9" : "R2");
            if (s == 2) check_val(stk_push_addr, pc, "R3 push addr");
            if (s == 3) check_val(ip_load_val, VEC, "R3 vector");
            cur_pc = pc ^ 16'hFFFF ^ 16'(s);
            host_dbg_req = (mode == 1) ? trig[0] : 1'b0;
            bkpt_hit = (mode == 1) ? trig[1] : 1'b0;
            ret_req = (mode == 2) && (s < 5);
        end
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            check_step(5, ige, (mode == 1) ? "R5 held" : "R7");
        end
        host_dbg_req = 1'b0;
        bkpt_hit = 1'b0;
        ret_req = 1'b1;
        @(negedge clk);
        check_step(6, ige, "R8 return");
        ret_req = 1'b0;
        @(negedge clk);
        check_step(0, ige, "R8 idle");
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_step(0, 1'b0, "R10 reset");
        // R9: return strobe while idle is ignored.
        ret_req = 1'b1;
        @(negedge clk);
        check_step(0, 1'b0, "R9 idle ret");
        ret_req = 1'b0;
        tmr_run = 4'b0110;
        wdt_run = 1'b0;
        @(negedge clk);
        check_step(0, 1'b0, "R6 idle follow");
        tmr_run = 4'b1011;
        wdt_run = 1'b1;
        for (int t = 1; t <= 3; t++)
            for (int g = 0; g <= 1; g++)
                for (int m = 0; m <= 2; m++)
                    run_case(t, g[0], m, 16'(16'h1234 + t * 97 + g * 13 + m * 5));
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule